// File: doc/BRIEF.md
# Change-of-State Digital I/O Register Block

This block is a small memory-mapped digital I/O controller. A 16-byte window on a synchronous 32-bit register bus with byte-lane strobes holds four words. Word 0 holds the output latches. Word 1 holds the synchronized input states. Word 2 holds the change-of-state flags. Word 3 holds the control, detection-enable and soft-reset bytes. The block drives 24 fixed output lines and reads 24 fixed input lines. It also has an 8-line TTL byte that is either driven from its own latch or used as an input, as a control bit selects.

Every input line passes through a two-flop synchronizer. Edge detection runs on the synchronized values and latches a per-line flag into a 32-bit write-one-to-clear word. The lines fall into four 8-line groups: input bytes 0 to 2 and the TTL byte. Each group can arm rising-edge and falling-edge detection separately. A single level interrupt stays high while any flag is set. Software clears flags by writing ones back to them, and a write to the top byte of word 3 returns the block to its reset state.

Top module: `cos_gpio_regs`

## Requirements
- R1: Word 0 holds the output latches: bits 23:0 drive `out_lines` and bits 31:24 form the TTL output latch. A read returns the last value written.
- R2: A write updates only the bytes whose `bus_be` bit is set. Bit i of `bus_be` covers data bits 8i+7:8i. In word 2 a clear bit in a disabled lane has no effect.
- R3: Word 1 reads the input lines in bits 23:0 and the TTL pins in bits 31:24. A pin change is visible on a read two clock edges after it is applied, and not after one. Writes to word 1 change no register.
- R4: Word 3 bit 1 is the TTL direction: 1 drives the TTL pins from the latch (`ttl_oe`=1), and 0 makes them inputs. Every other bit of byte 0 and all of byte 1 read as 0.
- R5: Word 3 bits 23:16 are the detection enables. For group g (0 to 2 = input bytes, 3 = TTL byte), bit 16+g arms rising edges and bit 20+g arms falling edges. An edge in a disarmed direction sets no flag.
- R6: Word 2 holds the flags, with line k of group g at bit 8g+k. A flag sets three clock edges after its pin edge and stays set until a write to word 2 carries a one in its bit.
- R7: When an edge sets a flag in the same cycle that a write clears it, the flag stays set.
- R8: `irq` is high exactly while at least one flag is set.
- R9: A write to word 3 with `bus_be[3]` set clears the output latches, the direction bit, the enables and all flags. The write to the other bytes of that word is then discarded.
- R10: After reset every register reads 0, `out_lines`, `ttl_out` and `ttl_oe` are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address (byte offset bits 3:2) |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| in_lines | input | 24 | Fixed input lines |
| out_lines | output | 24 | Fixed output lines |
| ttl_in | input | 8 | TTL pin values as seen at the pads |
| ttl_out | output | 8 | TTL output latch value |
| ttl_oe | output | 1 | TTL output enable (1 = drive pins) |
| irq | output | 1 | Level interrupt, any flag set |

## Verification
A vector table of writes and reads covers full-word and single-lane writes to the output latches, writes to the input word, and control writes with all bits set. This separates byte-lane gating, readback and reserved-bit masking. Edge tests use a rising edge on an armed line together with one on a disarmed group, which tells the direction and group enables apart. A falling edge timed to land on a clear of the same bit separates set-over-clear priority from plain write-one-to-clear. A clear with the TTL lane strobe off, followed by a soft reset, shows the lane gating on the flag word and the full return to the reset state.

// File: rtl/cos_gpio_pkg.sv
package cos_gpio_pkg;
  localparam int LANE_W      = 8;
  localparam int GROUPS      = 4;
  localparam int CTL_OE_BIT  = 1;

  typedef enum logic [1:0] {
    W_OUT = 2'd0,
    W_IN  = 2'd1,
    W_COS = 2'd2,
    W_CTL = 2'd3
  } word_e;
endpackage

// File: rtl/cos_gpio_rst_sync.sv
module cos_gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] st_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= '0;
    else         st_q <= {st_q[0], 1'b1};
  end

  assign rst_n_o = st_q[1];
endmodule

// File: rtl/cos_gpio_sync.sv
module cos_gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cos_gpio_cos.sv
module cos_gpio_cos #(
  parameter int LANE_W = 8,
  parameter int GROUPS = 4,
  parameter int W      = LANE_W * GROUPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    cur_i,
  input  logic [W-1:0]    clr_i,
  input  logic [2*GROUPS-1:0] en_i,
  input  logic            soft_i,
  output logic [W-1:0]    flags_o
);
  logic [W-1:0] prev_q, flags_q, flags_d, set_w;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign set_w[g*LANE_W +: LANE_W] =
        ( cur_i[g*LANE_W +: LANE_W] & ~prev_q[g*LANE_W +: LANE_W] & {LANE_W{en_i[g]}})
      | (~cur_i[g*LANE_W +: LANE_W] &  prev_q[g*LANE_W +: LANE_W] & {LANE_W{en_i[g+GROUPS]}});
  end

  // set wins over clear; soft reset wins over both
  always_comb begin
    if (soft_i) flags_d = '0;
    else        flags_d = (flags_q & ~clr_i) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= cur_i;
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_i |=> ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0)); // R6

  AST_NO_SET_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0)); // R5
endmodule

// File: rtl/cos_gpio_regs.sv
module cos_gpio_regs
  import cos_gpio_pkg::*;
#(
  parameter int LW   = LANE_W,
  parameter int NG   = GROUPS,
  parameter int DW   = LW * NG,
  parameter int NFIX = LW * (NG - 1)
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [NG-1:0]   bus_be,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NFIX-1:0] in_lines,
  output logic [NFIX-1:0] out_lines,
  input  logic [LW-1:0]   ttl_in,
  output logic [LW-1:0]   ttl_out,
  output logic            ttl_oe,
  output logic            irq
);
  localparam int EN_W = 2 * NG;

  logic            rs_n;
  word_e           waddr;
  logic [DW-1:0]   olat_q, olat_d;
  logic            oe_q, oe_d;
  logic [EN_W-1:0] en_q, en_d;
  logic            soft_w, reg_en;
  logic [DW-1:0]   clr_w, syn_w, flags_w, rd_ctl;

  cos_gpio_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rs_n));

  cos_gpio_sync #(.W(DW)) u_sync (
    .clk(clk), .rst_n(rs_n), .d_i({ttl_in, in_lines}), .q_o(syn_w)
  );

  assign waddr  = word_e'(bus_addr);
  assign soft_w = bus_wr && (waddr == W_CTL) && bus_be[NG-1];
  assign reg_en = bus_wr;

  for (genvar i = 0; i < NG; i++) begin : g_clr
    assign clr_w[i*LW +: LW] = (bus_wr && (waddr == W_COS) && bus_be[i])
                               ? bus_wdata[i*LW +: LW] : '0;
  end

  cos_gpio_cos #(.LANE_W(LW), .GROUPS(NG), .W(DW)) u_cos (
    .clk(clk), .rst_n(rs_n), .cur_i(syn_w), .clr_i(clr_w),
    .en_i(en_q), .soft_i(soft_w), .flags_o(flags_w)
  );

  // next state of the software-written registers
  always_comb begin
    olat_d = olat_q;
    oe_d   = oe_q;
    en_d   = en_q;
    if (soft_w) begin
      olat_d = '0;
      oe_d   = 1'b0;
      en_d   = '0;
    end else if (bus_wr) begin
      case (waddr)
        W_OUT: begin
          for (int i = 0; i < NG; i++)
            if (bus_be[i]) olat_d[i*LW +: LW] = bus_wdata[i*LW +: LW];
        end
        W_CTL: begin
          if (bus_be[0]) oe_d = bus_wdata[CTL_OE_BIT];
          if (bus_be[2]) en_d = bus_wdata[2*LW +: EN_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      olat_q <= '0;
      oe_q   <= 1'b0;
      en_q   <= '0;
    end else if (reg_en) begin
      olat_q <= olat_d;
      oe_q   <= oe_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    rd_ctl = '0;
    rd_ctl[2*LW +: EN_W] = en_q;
    rd_ctl[CTL_OE_BIT]   = oe_q;
  end

  always_comb begin
    case (waddr)
      W_OUT:   bus_rdata = olat_q;
      W_IN:    bus_rdata = syn_w;
      W_COS:   bus_rdata = flags_w;
      default: bus_rdata = rd_ctl;
    endcase
  end

  assign out_lines = olat_q[NFIX-1:0];
  assign ttl_out   = olat_q[DW-1 -: LW];
  assign ttl_oe    = oe_q;
  assign irq       = |flags_w;

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rs_n)
    soft_w |=> (out_lines == '0 && ttl_out == '0 && !ttl_oe && en_q == '0 && !irq)); // R9

  AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rs_n)
    (bus_wr && waddr == W_IN) |=> ($stable(olat_q) && $stable(en_q) && $stable(oe_q))); // R3

  AST_IRQ_NEEDS_ARMING: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(irq) |-> ($past(en_q) != '0)); // R5

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rs_n)
    (irq && !bus_wr) |=> irq); // R8
endmodule

// File: tb/test_cos_gpio_regs.sv
module test_cos_gpio_regs;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [23:0] in_lines, out_lines;
  logic [7:0]  ttl_in, ttl_out;
  logic        ttl_oe, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  cos_gpio_regs i_cos_gpio_regs (
    .clk(clk), .arst_n(arst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_lines(in_lines), .out_lines(out_lines), .ttl_in(ttl_in),
    .ttl_out(ttl_out), .ttl_oe(ttl_oe), .irq(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  a;
    logic [3:0]  be;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 4'hF, 32'hA5C3_0F11},  // R1 full write
    '{1'b1, 2'd0, 4'h0, 32'hA5C3_0F11},  // R1 readback
    '{1'b0, 2'd0, 4'h2, 32'h0000_FF00},  // R2 one lane
    '{1'b1, 2'd0, 4'h0, 32'hA5C3_FF11},  // R2
    '{1'b0, 2'd1, 4'hF, 32'hFFFF_FFFF},  // R3 write to inputs
    '{1'b1, 2'd0, 4'h0, 32'hA5C3_FF11},  // R3 latches untouched
    '{1'b1, 2'd1, 4'h0, 32'h0000_0000},  // R3 inputs still low
    '{1'b0, 2'd3, 4'h4, 32'h00AA_0000},  // R5 enables only
    '{1'b1, 2'd3, 4'h0, 32'h00AA_0000},  // R5
    '{1'b0, 2'd3, 4'h3, 32'h0000_FFFF},  // R4 all ctl bits
    '{1'b1, 2'd3, 4'h0, 32'h00AA_0002},  // R4 only bit 1 kept
    '{1'b0, 2'd3, 4'h5, 32'h0000_0000},  // R4/R5 clear both
    '{1'b1, 2'd3, 4'h0, 32'h0000_0000}   // R4/R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    in_lines = '0; ttl_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10 reset state
    for (int w = 0; w < 4; w++) begin
      rd(w[1:0], rv);
      chk("R10 word", rv, 32'h0);
    end
    chk("R10 pins", {out_lines, ttl_out}, 32'h0);
    chk("R10 oe/irq", {30'h0, ttl_oe, irq}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        rd(VECS[i].a, rv);
        chk("R1/R2/R3/R4/R5 table", rv, VECS[i].d);
      end else begin
        wr(VECS[i].a, VECS[i].be, VECS[i].d);
      end
    end
    chk("R1 pins", {ttl_out, out_lines}, 32'hA5C3_FF11);

    // R4 direction pin, TTL input readback
    wr(2'd3, 4'h1, 32'h0000_0002);
    #1 chk("R4 oe", {31'h0, ttl_oe}, 32'h1);
    // R3 latency: applied at negedge, visible after two edges
    @(negedge clk);
    in_lines = 24'h00_0100; ttl_in = 8'h3C;
    rd(2'd1, rv);
    chk("R3 one edge", rv, 32'h0);
    rd(2'd1, rv);
    chk("R3 two edges", rv, 32'h3C00_0100);
    wr(2'd3, 4'h1, 32'h0);
    #1 chk("R4 input mode", {31'h0, ttl_oe}, 32'h0);
    @(negedge clk); in_lines = '0; ttl_in = '0;
    repeat (4) @(posedge clk);

    // R5/R6: arm group1 rise (bit17) and fall (bit21); group0 disarmed
    wr(2'd3, 4'h4, 32'h0022_0000);
    @(negedge clk);
    in_lines = 24'h00_0201;
    repeat (2) @(posedge clk);
    rd(2'd2, rv);
    chk("R6 not yet set", rv, 32'h0);
    rd(2'd2, rv);
    chk("R5/R6 rise flag", rv, 32'h0000_0200);
    chk("R8 irq high", {31'h0, irq}, 32'h1);

    // R7 falling edge lands on a clear of the same bit
    @(negedge clk);
    in_lines = 24'h00_0001;
    repeat (2) @(posedge clk);
    wr(2'd2, 4'hF, 32'h0000_0200);
    rd(2'd2, rv);
    chk("R7 set beats clear", rv, 32'h0000_0200);
    wr(2'd2, 4'hF, 32'h0000_0200);
    rd(2'd2, rv);
    chk("R6 w1c", rv, 32'h0);
    chk("R8 irq low", {31'h0, irq}, 32'h0);

    // TTL group: rise armed (bit19), fall disarmed
    wr(2'd3, 4'h4, 32'h0008_0000);
    @(negedge clk); ttl_in = 8'h04;
    repeat (4) @(posedge clk);
    rd(2'd2, rv);
    chk("R5/R6 ttl rise", rv, 32'h0400_0000);
    @(negedge clk); ttl_in = 8'h00;
    repeat (4) @(posedge clk);
    rd(2'd2, rv);
    chk("R5 fall disarmed", rv, 32'h0400_0000);
    wr(2'd2, 4'h7, 32'hFFFF_FFFF);
    rd(2'd2, rv);
    chk("R2 lane gated clear", rv, 32'h0400_0000);

    // R9 soft reset with a control byte in the same write
    wr(2'd0, 4'hF, 32'h1234_5678);
    wr(2'd3, 4'h1, 32'h0000_0002);
    wr(2'd3, 4'h9, 32'h0000_0002);
    rd(2'd0, rv);
    chk("R9 latches", rv, 32'h0);
    rd(2'd3, rv);
    chk("R9 ctl/enable", rv, 32'h0);
    rd(2'd2, rv);
    chk("R9 flags", rv, 32'h0);
    chk("R9 pins", {6'h0, ttl_oe, irq, out_lines}, 32'h0);

    finish_run();
  end
endmodule